// File: doc/BRIEF.md
# Byte-Lane Data Memory

A small synchronous data store organised as rows of eight bytes. A client issues one request per cycle carrying a byte address, an access size of one, two, four or eight bytes, an optional write with its data, and a byte-reversal control. The row is selected by the address bits above the low three. Those low three bits give the starting byte inside the row.

A load pulls out only the addressed bytes, moves them down to bit zero and returns them zero-extended one cycle later with a valid pulse. A store merges its bytes into the existing row and leaves every other byte of that row as it was.

A request whose byte offset is not a multiple of its size is refused. It returns an error pulse one cycle later and changes no state. When byte reversal is requested, the bytes of the item are mirrored within its own width. For stores this happens before the merge; for loads it happens after the extraction.

Top module: `lane_mem`

## Requirements
- R1: After reset every row reads as zero, and `rsp_valid`, `rsp_misalign` and `rsp_rdata` are all zero.
- R2: The row index is `req_addr[6:3]` for the default depth of 16. Address bits above the index have no effect, so two addresses that differ only there reach the same row.
- R3: A legal load (`req_valid`=1, `req_we`=0) raises `rsp_valid` in the next cycle. `rsp_rdata` then holds the addressed bytes shifted down by offset×8 and zero-extended. Size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes.
- R4: A legal store replaces only the bytes at offsets offset to offset+width−1 of the row, using the low width bytes of `req_wdata`. An 8-byte store replaces the whole row.
- R5: A request whose offset (`req_addr[2:0]`) is not a multiple of its width raises `rsp_misalign` in the next cycle. It keeps `rsp_valid` low and leaves every row unchanged.
- R6: A load with `req_swap`=1 returns the extracted item with its width bytes in reverse order.
- R7: A store with `req_swap`=1 reverses the low width bytes of `req_wdata` before merging them into the row.
- R8: `rsp_rdata` holds its value in every cycle that does not follow a legal load.
- R9: Stores and idle cycles produce no `rsp_valid` pulse, and `rsp_valid` and `rsp_misalign` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 64 | Byte address |
| req_size | input | 2 | Access size code: 0/1/2/3 = 1/2/4/8 bytes |
| req_wdata | input | 64 | Store data, item in the low bytes |
| req_swap | input | 1 | Reverse the item's byte order |
| rsp_valid | output | 1 | Load data valid, one cycle after a legal load |
| rsp_rdata | output | 64 | Zero-extended load data |
| rsp_misalign | output | 1 | Misaligned request refused, one cycle after it |

## Verification
The hardest case to provoke is a partial store that must leave the neighbouring bytes of a row untouched while that row already holds mixed data from earlier stores of other sizes and byte orders. The stimulus reaches it by repeatedly hitting the 16 rows with random sizes, offsets and swap settings, so most rows collect overlapping partial writes. A reference image in the bench tracks every row, and each later load is compared against it. Misaligned requests and address bits above the row index are also mixed in at random. A refused store or an aliased address that corrupts a row therefore appears as a wrong value on a later load.

// File: rtl/lane_mem_pkg.sv
package lane_mem_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } size_e;

  localparam int ROW_BYTES = 8;
  localparam int ROW_BITS  = ROW_BYTES * 8;
  localparam int OFF_W     = $clog2(ROW_BYTES);
endpackage

// File: rtl/lane_decode.sv
module lane_decode
  import lane_mem_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 4
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [1:0]          size,
  output logic [IDX_W-1:0]    idx,
  output logic [OFF_W-1:0]    off,
  output logic                misalign,
  output logic [ROW_BITS-1:0] lane_mask
);
  logic [OFF_W-1:0] width_m1;
  logic             unused_addr_hi;

  assign idx            = addr[OFF_W +: IDX_W];
  assign off            = addr[OFF_W-1:0];
  assign unused_addr_hi = ^addr[ADDR_W-1:OFF_W+IDX_W];

  always_comb begin
    case (size)
      SZ_BYTE: width_m1 = 3'd0;
      SZ_HALF: width_m1 = 3'd1;
      SZ_WORD: width_m1 = 3'd3;
      default: width_m1 = 3'd7;
    endcase
    misalign = |(off & width_m1);
    for (int b = 0; b < ROW_BYTES; b++) begin
      lane_mask[b*8 +: 8] = {8{(4'(b) >= {1'b0, off}) &&
                               (4'(b) <= ({1'b0, off} + {1'b0, width_m1}))}};
    end
  end
endmodule

// File: rtl/lane_swap.sv
module lane_swap
  import lane_mem_pkg::*;
(
  input  logic                en,
  input  logic [1:0]          size,
  input  logic [ROW_BITS-1:0] d,
  output logic [ROW_BITS-1:0] q
);
  logic [ROW_BITS-1:0] rev [4];

  for (genvar s = 0; s < 4; s++) begin : g_width
    localparam int NB = 1 << s;
    always_comb begin
      rev[s] = '0;
      for (int i = 0; i < NB; i++) begin
        rev[s][i*8 +: 8] = d[(NB-1-i)*8 +: 8];
      end
    end
  end

  always_comb begin
    if (en) q = rev[size];
    else    q = d;
  end
endmodule

// File: rtl/lane_rows.sv
module lane_rows
  import lane_mem_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    idx,
  input  logic [ROW_BITS-1:0] wmask,
  input  logic [ROW_BITS-1:0] wdata,
  output logic [ROW_BITS-1:0] rd_row
);
  logic [ROW_BITS-1:0] row_q [DEPTH];

  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    logic                row_en;
    logic [ROW_BITS-1:0] row_d;

    always_comb begin
      row_en = wr_en && (idx == IDX_W'(r));
      row_d  = (row_q[r] & ~wmask) | (wdata & wmask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      row_q[r] <= '0;
      else if (row_en) row_q[r] <= row_d;
    end
  end

  assign rd_row = row_q[idx];
endmodule

// File: rtl/lane_mem.sv
module lane_mem
  import lane_mem_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [63:0]       req_wdata,
  input  logic              req_swap,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  output logic              rsp_misalign
);
  logic [IDX_W-1:0]    idx;
  logic [OFF_W-1:0]    off;
  logic                misalign;
  logic [ROW_BITS-1:0] lane_mask;
  logic [5:0]          shamt;
  logic [ROW_BITS-1:0] item_mask;
  logic [ROW_BITS-1:0] rd_row;
  logic [ROW_BITS-1:0] ld_raw;
  logic [ROW_BITS-1:0] ld_item;
  logic [ROW_BITS-1:0] st_raw;
  logic [ROW_BITS-1:0] st_item;
  logic [ROW_BITS-1:0] st_lanes;
  logic                wr_en;
  logic                ld_ok;

  logic                valid_d, valid_q;
  logic                mis_d, mis_q;
  logic [ROW_BITS-1:0] rdata_q;

  lane_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .addr      (req_addr),
    .size      (req_size),
    .idx       (idx),
    .off       (off),
    .misalign  (misalign),
    .lane_mask (lane_mask)
  );

  always_comb begin
    shamt     = {off, 3'b000};
    item_mask = lane_mask >> shamt;
    ld_raw    = (rd_row & lane_mask) >> shamt;
    st_raw    = req_wdata & item_mask;
    st_lanes  = st_item << shamt;
    wr_en     = req_valid && req_we && !misalign;
    ld_ok     = req_valid && !req_we && !misalign;
    valid_d   = ld_ok;
    mis_d     = req_valid && misalign;
  end

  lane_swap u_ld_swap (
    .en   (req_swap),
    .size (req_size),
    .d    (ld_raw),
    .q    (ld_item)
  );

  lane_swap u_st_swap (
    .en   (req_swap),
    .size (req_size),
    .d    (st_raw),
    .q    (st_item)
  );

  lane_rows #(.DEPTH(DEPTH)) u_rows (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .idx    (idx),
    .wmask  (lane_mask),
    .wdata  (st_lanes),
    .rd_row (rd_row)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mis_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      mis_q   <= mis_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (ld_ok) rdata_q <= ld_item;
  end

  assign rsp_valid    = valid_q;
  assign rsp_misalign = mis_q;
  assign rsp_rdata    = rdata_q;
endmodule

// File: rtl/lane_mem_chk.sv
module lane_mem_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_we,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic              rsp_valid,
  input logic [63:0]       rsp_rdata,
  input logic              rsp_misalign
);
  logic bad_off;
  always_comb begin
    case (req_size)
      2'd0:    bad_off = 1'b0;
      2'd1:    bad_off = req_addr[0];
      2'd2:    bad_off = |req_addr[1:0];
      default: bad_off = |req_addr[2:0];
    endcase
  end

  p_load_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we && !bad_off) |=> rsp_valid);

  p_misalign_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && bad_off) |=> (rsp_misalign && !rsp_valid));

  p_hold_rdata_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_we && !bad_off) |=> $stable(rsp_rdata));

  p_no_store_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || req_we) |=> !rsp_valid);

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && rsp_misalign));

  p_quiet_after_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && bad_off) |=> !rsp_misalign);
endmodule

bind lane_mem lane_mem_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/lane_mem_bench.sv
module lane_mem_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_we, req_swap;
  logic [63:0] req_addr, req_wdata;
  logic [1:0]  req_size;
  logic        rsp_valid, rsp_misalign;
  logic [63:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  logic [63:0] img [16];
  logic [63:0] last_rdata;

  always #2 clk = ~clk;

  lane_mem u_lane_mem (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .req_swap(req_swap), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_misalign(rsp_misalign)
  );

  function automatic logic [63:0] fmask(input logic [1:0] sz);
    return (sz == 2'd3) ? '1 : ((64'd1 << (8 << sz)) - 64'd1);
  endfunction

  function automatic logic [63:0] brev(input logic [63:0] v, input logic [1:0] sz);
    logic [63:0] r = '0;
    int w = 1 << sz;
    for (int i = 0; i < w; i++) r[i*8 +: 8] = v[(w-1-i)*8 +: 8];
    return r;
  endfunction

  function automatic bit is_bad(input logic [2:0] off, input logic [1:0] sz);
    return (off & 3'((1 << sz) - 1)) != 3'd0;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic we, input logic [63:0] addr, input logic [1:0] sz,
                    input logic [63:0] wd, input logic sw, input string req);
    logic [3:0]  row = addr[6:3];
    logic [2:0]  off = addr[2:0];
    bit          bad = is_bad(off, sz);
    logic [63:0] v, exp_data;
    req_valid = 1'b1; req_we = we; req_addr = addr; req_size = sz;
    req_wdata = wd; req_swap = sw;
    exp_data = last_rdata;
    if (!bad && !we) begin
      v = (img[row] >> (8*off)) & fmask(sz);
      exp_data = sw ? brev(v, sz) : v;
    end else if (!bad && we) begin
      v = wd & fmask(sz);
      if (sw) v = brev(v, sz);
      img[row] = (img[row] & ~(fmask(sz) << (8*off))) | (v << (8*off));
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " R5 misalign flag"}, 64'(rsp_misalign), 64'(bad));
    check({req, " R9 valid"}, 64'(rsp_valid), 64'(!bad && !we));
    check({req, " data (R8 hold otherwise)"}, rsp_rdata, exp_data);
    last_rdata = exp_data;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = '0;
    req_size = '0; req_wdata = '0; req_swap = 1'b0;
    last_rdata = '0;
    for (int i = 0; i < 16; i++) img[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset valid", 64'(rsp_valid), 64'd0);
    check("R1 reset misalign", 64'(rsp_misalign), 64'd0);
    check("R1 reset rdata", rsp_rdata, 64'd0);
    for (int r = 0; r < 16; r++) op(1'b0, 64'(r*8), 2'd3, '0, 1'b0, "R1 zero row");
    op(1'b1, 64'h0000_0000_0000_0020, 2'd3, 64'h1122_3344_5566_7788, 1'b0, "R4 full store");
    op(1'b1, 64'h0000_0000_0000_0025, 2'd0, 64'hFFFF_FFFF_FFFF_FFAB, 1'b0, "R4 byte store");
    op(1'b0, 64'h0000_0000_0000_0020, 2'd3, '0, 1'b0, "R4 merged row");
    op(1'b0, 64'h0000_0000_0000_0024, 2'd2, '0, 1'b0, "R3 word load");
    op(1'b0, 64'h0000_0000_0000_0022, 2'd1, '0, 1'b1, "R6 swapped half");
    op(1'b1, 64'h0000_0000_0000_0022, 2'd2, 64'hDEAD_BEEF, 1'b0, "R5 misaligned store");
    op(1'b0, 64'h0000_0000_0000_0020, 2'd3, '0, 1'b0, "R5 row unchanged");
    op(1'b0, 64'h0000_0000_0000_0021, 2'd1, '0, 1'b0, "R5 misaligned load");
    op(1'b1, 64'hABCD_0000_0000_0048, 2'd2, 64'h0102_0304, 1'b1, "R7 swapped store");
    op(1'b0, 64'h0000_0000_0000_0048, 2'd3, '0, 1'b0, "R2 alias R7 readback");
    op(1'b0, 64'hFFFF_FFFF_FFFF_FF88, 2'd3, '0, 1'b0, "R2 high bits ignored");
    for (int n = 0; n < 600; n++) begin
      logic [63:0] a = {$urandom, $urandom};
      logic [1:0]  sz = 2'($urandom % 4);
      logic [2:0]  off = 3'($urandom % 8);
      if (($urandom % 8) != 0) off = off & ~3'((1 << sz) - 1);
      a[2:0] = off;
      op(1'($urandom % 2), a, sz, {$urandom, $urandom}, 1'($urandom % 2), "R3/R4/R6/R7 random");
    end
    for (int r = 0; r < 16; r++) op(1'b0, 64'(r*8), 2'd3, '0, 1'b0, "R4 final row");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule